// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block decides, for a bridge between a primary and a secondary bus, which memory accesses cross it. It holds two address windows. One is for non-prefetchable memory and one is for prefetchable memory. Each window is kept in a 32-bit configuration word that software reaches through a small register port. The port carries an offset, a write strobe, byte enables, write data and read data.

Each window has a 12-bit lower bound and a 12-bit upper bound. Both are compared with address bits 31:20, so the windows are aligned to 1 MB. The lower bound is inclusive and the upper bound is exclusive. A downstream address that hits either window is marked for forwarding to the secondary bus, provided the memory-space enable is set. An upstream address from the secondary bus that misses both windows is marked as accepted, provided the bus-master enable is set. Both decode outputs are combinational from the addresses and the registered fields.

Top module: `mem_window_decoder`

## Requirements
- R1: After reset the non-prefetchable word (offset 20h) reads 00000000h and the prefetchable word (offset 24h) reads 00010001h.
- R2: In each window word, the lower bound occupies bits 15:4 and the upper bound occupies bits 31:20. A write updates only the bytes whose byte enable (cfg_be[n] for bits 8n+7:8n) is 1.
- R3: Bits 19:16 and 3:0 cannot be written. They read as 0 in the non-prefetchable word and as 1 in the prefetchable word.
- R4: An address is inside a window only when its bits 31:20 are greater than or equal to the lower bound.
- R5: An address is inside a window only when its bits 31:20 are strictly less than the upper bound.
- R6: A window whose lower bound is greater than or equal to its upper bound contains no address.
- R7: dn_fwd is 1 exactly when mem_en is 1 and dn_addr lies inside at least one window.
- R8: up_accept is 1 exactly when bus_master_en is 1 and up_addr lies inside neither window.
- R9: A read at any offset other than 20h and 24h returns zero. A write at any other offset changes no window.
- R10: A write becomes visible in read data and in decoding only after the rising clock edge that captures it. Without a write, the window words hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Register offset in bytes |
| cfg_we | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| mem_en | input | 1 | Memory-space enable |
| bus_master_en | input | 1 | Bus-master enable |
| dn_addr | input | 32 | Downstream access address |
| dn_fwd | output | 1 | Forward the downstream access to the secondary bus |
| up_addr | input | 32 | Upstream access address |
| up_accept | output | 1 | Accept the upstream access |

## Verification
The bench probes each window one step below its lower bound, exactly at it, at the last address before its upper bound and at the upper bound itself. A decoder with the comparisons swapped or off by one would then forward or accept one MB too many or too few. Writes that set all-ones into the fixed bits catch a design that stores them, and a single-byte write catches one that ignores the byte enables. A bound pair with the lower bound above the upper bound catches a design that wraps an inverted window around the address space. Reads taken before the capturing edge catch a write path that leaks straight through to the read data. Each enable is also turned off while the address still hits, which catches outputs left ungated.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int OFS_W   = 8;
  localparam int FLD_W   = 12;
  localparam int NUM_WIN = 2;
  localparam int NUM_BE  = DATA_W / 8;
  localparam int LO_POS  = 4;
  localparam int HI_POS  = 20;

  localparam logic [DATA_W-1:0] WR_MASK =
    {{FLD_W{1'b1}}, 4'h0, {FLD_W{1'b1}}, 4'h0};

  typedef struct packed {
    logic [FLD_W-1:0] lo;
    logic [FLD_W-1:0] hi;
  } win_bounds_t;

  function automatic logic [OFS_W-1:0] win_offset(input int w);
    return OFS_W'(8'h20 + 4 * w);
  endfunction

  function automatic logic [DATA_W-1:0] win_fixed(input int w);
    return (w == 1) ? 32'h0001_0001 : 32'h0000_0000;
  endfunction
endpackage

// File: rtl/mwd_window_reg.sv
module mwd_window_reg
  import mwd_pkg::*;
#(
  parameter logic [OFS_W-1:0]  OFFSET = 8'h20,
  parameter logic [DATA_W-1:0] FIXED  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  cfg_addr,
  input  logic              cfg_we,
  input  logic [NUM_BE-1:0] cfg_be,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              sel_o,
  output logic [DATA_W-1:0] rdata_o,
  output win_bounds_t       bounds_o
);
  localparam logic [DATA_W-1:0] FIX_MASK = ~WR_MASK;

  logic [DATA_W-1:0] img_q, img_d;
  logic              wr_en;

  assign sel_o = (cfg_addr == OFFSET);
  assign wr_en = sel_o && cfg_we;

  always_comb begin
    img_d = img_q;
    if (wr_en) begin
      for (int b = 0; b < NUM_BE; b++) begin
        if (cfg_be[b]) begin
          img_d[8*b +: 8] = cfg_wdata[8*b +: 8] & WR_MASK[8*b +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q <= '0;
    end else if (wr_en) begin
      img_q <= img_d;
    end
  end

  assign bounds_o.lo = img_q[LO_POS +: FLD_W];
  assign bounds_o.hi = img_q[HI_POS +: FLD_W];
  assign rdata_o     = sel_o ? ((img_q & WR_MASK) | (FIXED & FIX_MASK)) : '0;

  // R10: the stored word moves only on a write to this offset
  p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(img_q));
endmodule

// File: rtl/mwd_range_cmp.sv
module mwd_range_cmp
  import mwd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  win_bounds_t       bounds,
  output logic              hit
);
  logic [FLD_W-1:0] page;
  logic             above_lo, below_hi;

  assign page     = addr[ADDR_W-1 -: FLD_W];
  assign above_lo = (page >= bounds.lo);
  assign below_hi = (page <  bounds.hi);
  assign hit      = above_lo && below_hi;
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import mwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_addr,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              mem_en,
  input  logic              bus_master_en,
  input  logic [31:0]       dn_addr,
  output logic              dn_fwd,
  input  logic [31:0]       up_addr,
  output logic              up_accept
);
  logic [NUM_WIN-1:0] dn_hit, up_hit, win_sel;
  logic [DATA_W-1:0]  win_rd [NUM_WIN];
  win_bounds_t        win_bnd [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    mwd_window_reg #(
      .OFFSET (win_offset(w)),
      .FIXED  (win_fixed(w))
    ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_addr  (cfg_addr),
      .cfg_we    (cfg_we),
      .cfg_be    (cfg_be),
      .cfg_wdata (cfg_wdata),
      .sel_o     (win_sel[w]),
      .rdata_o   (win_rd[w]),
      .bounds_o  (win_bnd[w])
    );

    mwd_range_cmp u_dn_cmp (
      .addr   (dn_addr),
      .bounds (win_bnd[w]),
      .hit    (dn_hit[w])
    );

    mwd_range_cmp u_up_cmp (
      .addr   (up_addr),
      .bounds (win_bnd[w]),
      .hit    (up_hit[w])
    );

    // R6: an inverted or zero-size window matches nothing in either direction
    p_empty_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_bnd[w].lo >= win_bnd[w].hi) |-> (!dn_hit[w] && !up_hit[w]));
  end

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      cfg_rdata = cfg_rdata | win_rd[w];
    end
  end

  assign dn_fwd    = mem_en && (|dn_hit);
  assign up_accept = bus_master_en && !(|up_hit);

  p_fwd_needs_mse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_fwd |-> mem_en);
  p_accept_needs_bme_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_accept |-> bus_master_en);
  // R7/R8: the same address is never both sent down and taken up
  p_dir_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_addr == up_addr) |-> !(dn_fwd && up_accept));
  p_unmapped_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sel == '0) |-> (cfg_rdata == '0));
  p_single_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel));
endmodule

// File: tb/mem_window_decoder_bench.sv
module mem_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_addr;
  logic        cfg_we;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        mem_en, bus_master_en;
  logic [31:0] dn_addr, up_addr;
  logic        dn_fwd, up_accept;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mem_window_decoder u_mem_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_en(mem_en), .bus_master_en(bus_master_en), .dn_addr(dn_addr),
    .dn_fwd(dn_fwd), .up_addr(up_addr), .up_accept(up_accept)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = ofs; cfg_be = be; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] ofs, input logic [31:0] exp);
    cfg_addr = ofs;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic dn(input string req, input logic [31:0] a, input logic exp);
    dn_addr = a;
    #1;
    chk(req, {31'd0, dn_fwd}, {31'd0, exp});
  endtask

  task automatic up(input string req, input logic [31:0] a, input logic exp);
    up_addr = a;
    #1;
    chk(req, {31'd0, up_accept}, {31'd0, exp});
  endtask

  task automatic t_reset;
    rd("R1 np reset", 8'h20, 32'h0000_0000);
    rd("R1 pf reset", 8'h24, 32'h0001_0001);
    mem_en = 1'b1; bus_master_en = 1'b1;
    dn("R6 empty after reset", 32'h0000_0000, 1'b0);
    up("R8 outside empty windows", 32'h1234_5678, 1'b1);
  endtask

  task automatic t_fields;
    wr(8'h20, 4'hF, 32'h300F_100F);
    rd("R3 np fixed bits zero", 8'h20, 32'h3000_1000);
    wr(8'h24, 4'hF, 32'h8000_7000);
    rd("R3 pf fixed bits one", 8'h24, 32'h8001_7001);
    rd("R9 unmapped read", 8'h28, 32'h0);
    rd("R9 misaligned read", 8'h21, 32'h0);
  endtask

  task automatic t_bounds;
    mem_en = 1'b1;
    dn("R4 below np lower", 32'h0FFF_FFFF, 1'b0);
    dn("R4 np lower inclusive", 32'h1000_0000, 1'b1);
    dn("R5 last below np upper", 32'h2FFF_FFFF, 1'b1);
    dn("R5 np upper exclusive", 32'h3000_0000, 1'b0);
    dn("R4 pf lower inclusive", 32'h7000_0000, 1'b1);
    dn("R5 pf upper exclusive", 32'h8000_0000, 1'b0);
    dn("R7 between windows", 32'h5000_0000, 1'b0);
    mem_en = 1'b0;
    dn("R7 mem_en off", 32'h1800_0000, 1'b0);
    mem_en = 1'b1;
  endtask

  task automatic t_upstream;
    bus_master_en = 1'b1;
    up("R8 below both", 32'h0000_0000, 1'b1);
    up("R8 inside np", 32'h1000_0000, 1'b0);
    up("R8 inside pf", 32'h7500_0000, 1'b0);
    up("R8 at pf upper", 32'h8000_0000, 1'b1);
    bus_master_en = 1'b0;
    up("R8 bme off", 32'h9000_0000, 1'b0);
    bus_master_en = 1'b1;
  endtask

  task automatic t_byte_en;
    wr(8'h20, 4'b0010, 32'hFFFF_55FF);
    rd("R2 single byte", 8'h20, 32'h3000_5500);
    dn("R6 inverted window", 32'h2000_0000, 1'b0);
    dn("R6 inverted window hi", 32'h5600_0000, 1'b0);
    up("R6 inverted window up", 32'h2000_0000, 1'b1);
  endtask

  task automatic t_timing;
    @(negedge clk);
    cfg_addr = 8'h20; cfg_be = 4'hF; cfg_wdata = 32'h4000_2000; cfg_we = 1'b1;
    #1;
    chk("R10 old value before edge", cfg_rdata, 32'h3000_5500);
    dn_addr = 32'h2000_0000;
    #1;
    chk("R10 old decode before edge", {31'd0, dn_fwd}, 32'd0);
    @(negedge clk);
    cfg_we = 1'b0;
    rd("R10 new value after edge", 8'h20, 32'h4000_2000);
    dn("R10 new decode after edge", 32'h2000_0000, 1'b1);
    wr(8'h28, 4'hF, 32'hFFFF_FFFF);
    rd("R9 stray write np", 8'h20, 32'h4000_2000);
    rd("R9 stray write pf", 8'h24, 32'h8001_7001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_addr = '0; cfg_we = 1'b0; cfg_be = '0; cfg_wdata = '0;
    mem_en = 1'b0; bus_master_en = 1'b0; dn_addr = '0; up_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fields;
    t_bounds;
    t_upstream;
    t_byte_en;
    t_timing;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule